// File: doc/BRIEF.md
# Predicated Vector Tree Reducer

This block collapses a short vector of integer elements into a single scalar. It applies one two-input operation, chosen per run, that gives the same answer in any grouping. A predicate mask, together with a vector-length value, selects which element positions take part. The reduction runs over several clock cycles as a fixed pairwise tree. On each level, neighbouring live positions are combined into the lower position of each pair. Intermediate values are held only in participating destination positions. Positions outside the predicate keep the prior destination contents that were supplied at start.

A run begins with a one-cycle start pulse that carries the elements, the prior destination vector, the length, the mask, the operation code and a condition-mode bit. When the tree has finished, the block raises a one-cycle done pulse. The destination vector then shows the final scalar at the lowest participating position and deterministic partial results at the other participating positions. A condition flag summarises whether the step results were nonzero: either any step or every step, depending on the mode bit. Operation codes that depend on evaluation order are refused with an error pulse.

Top module: `tree_red_top`

## Requirements
- R1: opSel selects the operation: 0 wrapping add, 1 multiply keeping the low DATA_W bits, 2 unsigned minimum, 3 unsigned maximum, 4 bitwise OR.
- R2: opSel values 5 (subtract), 6 (divide) and 7 (reserved) are refused. On the edge that samples start, illegalOp and done both go high for one cycle. destOut and condFlag keep their previous values. Legal runs never raise illegalOp.
- R3: Position i takes part only when predMask[i] is 1 and i < vlIn. The elemIn value of every other position has no effect on any output.
- R4: Every position that does not take part shows, after start, the destIn value given with that start, and it holds that value throughout the run. There is no zeroing.
- R5: At done, the lowest participating position holds the left-to-right fold of the participating elements in index order.
- R6: The schedule is a fixed tree. Each level scans the live positions in ascending order and pairs them first with second, third with fourth, and so on. Each pair's result goes to the lower position and the higher position leaves the live set. An unpaired last position passes through. At done, every participating position holds the value this schedule leaves in it.
- R7: A step is "met" when its combined result is nonzero. With condAll 0, condFlag is 1 if any step met it; with condAll 1, condFlag is 1 if every step met it. With fewer than two participating positions there are no steps and condFlag is 0.
- R8: If start is sampled at edge k with n participating positions, done is high for exactly one cycle, after edge k+1+L, where L = ceil(log2 n) for n >= 2 and L = 0 otherwise.
- R9: A start pulse while a run is in progress is ignored: it neither changes the results of the run nor produces a second done.
- R10: After reset, destOut is all zero and done, illegalOp and condFlag are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request that launches a run |
| elemIn | input | MAX_VL*DATA_W | Source elements, position i at bits i*DATA_W upward |
| destIn | input | MAX_VL*DATA_W | Prior destination contents, same packing |
| vlIn | input | $clog2(MAX_VL+1) | Vector length |
| predMask | input | MAX_VL | Per-position predicate |
| opSel | input | 3 | Operation code |
| condAll | input | 1 | Condition mode: 0 any step, 1 every step |
| destOut | output | MAX_VL*DATA_W | Destination vector |
| condFlag | output | 1 | Condition summary of the last run |
| done | output | 1 | One-cycle completion pulse |
| illegalOp | output | 1 | One-cycle refusal pulse for an illegal code |

## Verification
Each run's completion is due 1+L cycles after the edge that samples start, where L is the tree depth for the number of participating positions. A refused code completes on that same edge. The bench drives inputs on falling edges. It then counts falling edges until done is seen, compares that count with the expected depth, and reads destOut, condFlag and illegalOp at that falling edge, where all of them are stable. One falling edge later, it confirms that done and illegalOp have dropped. This shows that each is a single-cycle pulse.

// File: rtl/tree_red_pkg.sv
package tree_red_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_MUL  = 3'd1,
    OP_MINU = 3'd2,
    OP_MAXU = 3'd3,
    OP_OR   = 3'd4,
    OP_SUB  = 3'd5,
    OP_DIV  = 3'd6,
    OP_RSVD = 3'd7
  } op_e;

  typedef struct packed {
    logic load;
    logic step;
    logic reject;
  } ctl_strobe_t;

  function automatic logic isLegalOp(op_e op);
    return (op == OP_ADD) || (op == OP_MUL) || (op == OP_MINU) ||
           (op == OP_MAXU) || (op == OP_OR);
  endfunction

endpackage

// File: rtl/tree_red_ctrl.sv
module tree_red_ctrl
  import tree_red_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  op_e         opIn,
  input  logic        fewLeft,
  output ctl_strobe_t strobe,
  output logic        done,
  output logic        illegalOp
);

  typedef enum logic {ST_IDLE, ST_RUN} state_e;
  state_e state;

  always_comb begin
    strobe        = '0;
    strobe.load   = (state == ST_IDLE) && start && isLegalOp(opIn);
    strobe.reject = (state == ST_IDLE) && start && !isLegalOp(opIn);
    strobe.step   = (state == ST_RUN) && !fewLeft;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      done      <= 1'b0;
      illegalOp <= 1'b0;
    end else begin
      done      <= strobe.reject || ((state == ST_RUN) && fewLeft);
      illegalOp <= strobe.reject;
      case (state)
        ST_IDLE: if (strobe.load) state <= ST_RUN;
        ST_RUN:  if (fewLeft) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // A refusal always completes the request in the same cycle
  assert_illegal_has_done_R2: assert property (@(posedge clk) disable iff (!rstN)
    illegalOp |-> done);

  // Completion is only reported once the live set has collapsed
  assert_done_when_reduced_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> fewLeft);

endmodule

// File: rtl/tree_red_sched.sv
module tree_red_sched
  import tree_red_pkg::*;
#(
  parameter int MAX_VL = 8,
  parameter int IDX_W  = $clog2(MAX_VL)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ctl_strobe_t                   strobe,
  input  logic [MAX_VL-1:0]             activeIn,
  output logic [MAX_VL-1:0]             pairLo,
  output logic [MAX_VL-1:0][IDX_W-1:0]  partnerIdx,
  output logic                          fewLeft
);

  logic [MAX_VL-1:0] liveMask;
  logic [MAX_VL-1:0] consumed;
  logic [IDX_W-1:0]  firstIdx;
  logic              haveFirst;

  // Ascending scan: first live slot of each pair becomes the keeper
  always_comb begin
    pairLo     = '0;
    partnerIdx = '0;
    consumed   = '0;
    firstIdx   = '0;
    haveFirst  = 1'b0;
    for (int i = 0; i < MAX_VL; i++) begin
      if (liveMask[i]) begin
        if (!haveFirst) begin
          firstIdx  = IDX_W'(i);
          haveFirst = 1'b1;
        end else begin
          pairLo[firstIdx]     = 1'b1;
          partnerIdx[firstIdx] = IDX_W'(i);
          consumed[i]          = 1'b1;
          haveFirst            = 1'b0;
        end
      end
    end
  end

  assign fewLeft = ($countones(liveMask) <= 1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      liveMask <= '0;
    end else if (strobe.load) begin
      liveMask <= activeIn;
    end else if (strobe.step) begin
      liveMask <= liveMask & ~consumed;
    end
  end

  // Every tree level strictly shrinks the live set
  assert_level_shrinks_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step |=> ($countones(liveMask) < $past($countones(liveMask))));

  // A level never revives a slot, so masked slots never join the tree
  assert_live_no_growth_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step |=> ((liveMask & ~$past(liveMask)) == '0));

endmodule

// File: rtl/tree_red_dp.sv
module tree_red_dp
  import tree_red_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int MAX_VL = 8,
  parameter int IDX_W  = $clog2(MAX_VL)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ctl_strobe_t                   strobe,
  input  logic [MAX_VL-1:0]             activeIn,
  input  logic [MAX_VL-1:0][DATA_W-1:0] elemIn,
  input  logic [MAX_VL-1:0][DATA_W-1:0] destIn,
  input  op_e                           opIn,
  input  logic                          condAllIn,
  input  logic [MAX_VL-1:0]             pairLo,
  input  logic [MAX_VL-1:0][IDX_W-1:0]  partnerIdx,
  output logic [MAX_VL-1:0][DATA_W-1:0] slotOut,
  output logic                          condFlag
);

  logic [MAX_VL-1:0][DATA_W-1:0] slots;
  logic [MAX_VL-1:0][DATA_W-1:0] combRes;
  logic [MAX_VL-1:0]             nzVec;
  logic [MAX_VL-1:0]             activeReg;
  op_e                           opReg;
  logic                          condAllReg;
  logic                          seenStep;
  logic                          accAny;
  logic                          accAll;

  function automatic logic [DATA_W-1:0] aluFn(op_e op, logic [DATA_W-1:0] a,
                                               logic [DATA_W-1:0] b);
    logic [DATA_W-1:0] prod;
    prod = a * b;
    case (op)
      OP_ADD:  return a + b;
      OP_MUL:  return prod;
      OP_MINU: return (a < b) ? a : b;
      OP_MAXU: return (a > b) ? a : b;
      OP_OR:   return a | b;
      default: return '0;
    endcase
  endfunction

  for (genvar g = 0; g < MAX_VL; g++) begin : gen_lane
    assign combRes[g] = aluFn(opReg, slots[g], slots[partnerIdx[g]]);
    assign nzVec[g]   = |combRes[g];

    // Slots outside the predicate hold their prior value through every level
    assert_masked_slot_kept_R4: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.step && !activeReg[g]) |=> $stable(slots[g]));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slots      <= '0;
      activeReg  <= '0;
      opReg      <= OP_ADD;
      condAllReg <= 1'b0;
      seenStep   <= 1'b0;
      accAny     <= 1'b0;
      accAll     <= 1'b1;
    end else if (strobe.load) begin
      for (int i = 0; i < MAX_VL; i++) begin
        slots[i] <= activeIn[i] ? elemIn[i] : destIn[i];
      end
      activeReg  <= activeIn;
      opReg      <= opIn;
      condAllReg <= condAllIn;
      seenStep   <= 1'b0;
      accAny     <= 1'b0;
      accAll     <= 1'b1;
    end else if (strobe.step) begin
      for (int i = 0; i < MAX_VL; i++) begin
        if (pairLo[i] && activeReg[i]) slots[i] <= combRes[i];
      end
      if (|pairLo) seenStep <= 1'b1;
      accAny <= accAny | (|(pairLo & nzVec));
      accAll <= accAll & (&(~pairLo | nzVec));
    end
  end

  assign slotOut  = slots;
  assign condFlag = seenStep && (condAllReg ? accAll : accAny);

  // Only order-independent operations ever reach the combiners
  assert_legal_op_run_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step |-> isLegalOp(opReg));

endmodule

// File: rtl/tree_red_top.sv
module tree_red_top
  import tree_red_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int MAX_VL = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       start,
  input  logic [MAX_VL*DATA_W-1:0]   elemIn,
  input  logic [MAX_VL*DATA_W-1:0]   destIn,
  input  logic [$clog2(MAX_VL+1)-1:0] vlIn,
  input  logic [MAX_VL-1:0]          predMask,
  input  logic [2:0]                 opSel,
  input  logic                       condAll,
  output logic [MAX_VL*DATA_W-1:0]   destOut,
  output logic                       condFlag,
  output logic                       done,
  output logic                       illegalOp
);

  localparam int IDX_W = (MAX_VL > 1) ? $clog2(MAX_VL) : 1;
  localparam int VL_W  = $clog2(MAX_VL + 1);

  logic [MAX_VL-1:0]             activeVec;
  logic [MAX_VL-1:0][DATA_W-1:0] elemArr;
  logic [MAX_VL-1:0][DATA_W-1:0] destArr;
  logic [MAX_VL-1:0][DATA_W-1:0] slotArr;
  logic [MAX_VL-1:0]             pairLo;
  logic [MAX_VL-1:0][IDX_W-1:0]  partnerIdx;
  logic                          fewLeft;
  ctl_strobe_t                   strobe;
  op_e                           opIn;

  assign opIn    = op_e'(opSel);
  assign elemArr = elemIn;
  assign destArr = destIn;
  assign destOut = slotArr;

  for (genvar g = 0; g < MAX_VL; g++) begin : gen_active
    localparam logic [VL_W-1:0] POS = VL_W'(g);
    assign activeVec[g] = predMask[g] && (POS < vlIn);
  end

  tree_red_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .opIn      (opIn),
    .fewLeft   (fewLeft),
    .strobe    (strobe),
    .done      (done),
    .illegalOp (illegalOp)
  );

  tree_red_sched #(.MAX_VL(MAX_VL), .IDX_W(IDX_W)) u_sched (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .activeIn   (activeVec),
    .pairLo     (pairLo),
    .partnerIdx (partnerIdx),
    .fewLeft    (fewLeft)
  );

  tree_red_dp #(.DATA_W(DATA_W), .MAX_VL(MAX_VL), .IDX_W(IDX_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .activeIn   (activeVec),
    .elemIn     (elemArr),
    .destIn     (destArr),
    .opIn       (opIn),
    .condAllIn  (condAll),
    .pairLo     (pairLo),
    .partnerIdx (partnerIdx),
    .slotOut    (slotArr),
    .condFlag   (condFlag)
  );

endmodule

// File: tb/tb_tree_red_top.sv
`timescale 1ns/1ps
module tb_tree_red_top;

  localparam int DW = 32;
  localparam int NV = 8;

  typedef struct packed {
    logic [2:0]  op;
    logic [3:0]  vl;
    logic [7:0]  mask;
    logic        cAll;
    logic [31:0] seed;
    logic [3:0]  lat;
  } vec_t;

  localparam int NVEC = 13;
  localparam vec_t TABLE [NVEC] = '{
    '{3'd0, 4'd8, 8'hFF, 1'b0, 32'h87654321, 4'd4},
    '{3'd1, 4'd5, 8'h1F, 1'b1, 32'h00032121, 4'd4},
    '{3'd2, 4'd8, 8'hA5, 1'b0, 32'h9A3C5E7F, 4'd3},
    '{3'd3, 4'd6, 8'hFF, 1'b1, 32'h0F1E2D3C, 4'd4},
    '{3'd4, 4'd8, 8'h81, 1'b1, 32'h50000003, 4'd2},
    '{3'd0, 4'd3, 8'hF0, 1'b0, 32'h11111111, 4'd1},
    '{3'd0, 4'd8, 8'h10, 1'b1, 32'h00050000, 4'd1},
    '{3'd0, 4'd0, 8'hFF, 1'b1, 32'h22222222, 4'd1},
    '{3'd4, 4'd7, 8'hFE, 1'b0, 32'h0ABCDEF1, 4'd4},
    '{3'd1, 4'd4, 8'h0F, 1'b1, 32'h00003021, 4'd3},
    '{3'd4, 4'd4, 8'h0F, 1'b0, 32'h00000000, 4'd3},
    '{3'd3, 4'd8, 8'h3C, 1'b0, 32'h00F0F000, 4'd3},
    '{3'd2, 4'd8, 8'hFF, 1'b1, 32'h12345670, 4'd4}
  };

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              start = 1'b0;
  logic [NV*DW-1:0]  elemIn = '0;
  logic [NV*DW-1:0]  destIn = '0;
  logic [3:0]        vlIn = '0;
  logic [NV-1:0]     predMask = '0;
  logic [2:0]        opSel = '0;
  logic              condAll = 1'b0;
  logic [NV*DW-1:0]  destOut;
  logic              condFlag;
  logic              done;
  logic              illegalOp;

  always #2 clk = ~clk;

  tree_red_top #(.DATA_W(DW), .MAX_VL(NV)) dut (
    .clk(clk), .rstN(rstN), .start(start), .elemIn(elemIn), .destIn(destIn),
    .vlIn(vlIn), .predMask(predMask), .opSel(opSel), .condAll(condAll),
    .destOut(destOut), .condFlag(condFlag), .done(done), .illegalOp(illegalOp)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  logic [31:0] elemV [NV];
  logic [31:0] destV [NV];
  logic [31:0] expSlot [NV];
  bit          expFlag;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 50000) begin
      errors++;
      $display("FAIL R8 watchdog expired actual=%0d expected=<50000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] refOp(logic [2:0] op, logic [31:0] a, logic [31:0] b);
    logic [31:0] p;
    p = a * b;
    case (op)
      3'd0: return a + b;
      3'd1: return p;
      3'd2: return (a < b) ? a : b;
      3'd3: return (a > b) ? a : b;
      default: return a | b;
    endcase
  endfunction

  // Reference tree from the requirement text (R5, R6, R7)
  task automatic model(input logic [2:0] op, input logic [3:0] vl,
                       input logic [7:0] mask, input bit cAll);
    logic [7:0]  live, nxt;
    bit          par, seen, anyNz, allNz;
    int          first;
    logic [31:0] r;
    for (int i = 0; i < NV; i++) begin
      live[i]    = mask[i] && (i < int'(vl));
      expSlot[i] = live[i] ? elemV[i] : destV[i];
    end
    seen = 0; anyNz = 0; allNz = 1;
    while ($countones(live) > 1) begin
      nxt = live; par = 0; first = 0;
      for (int i = 0; i < NV; i++) begin
        if (live[i]) begin
          if (!par) begin
            first = i; par = 1;
          end else begin
            r = refOp(op, expSlot[first], expSlot[i]);
            expSlot[first] = r;
            nxt[i] = 1'b0;
            seen = 1; anyNz |= (r != 0); allNz &= (r != 0);
            par = 0;
          end
        end
      end
      live = nxt;
    end
    expFlag = seen && (cAll ? allNz : anyNz);
  endtask

  task automatic drive(input logic [2:0] op, input logic [3:0] vl,
                       input logic [7:0] mask, input bit cAll);
    for (int i = 0; i < NV; i++) begin
      elemIn[i*DW +: DW] = elemV[i];
      destIn[i*DW +: DW] = destV[i];
    end
    opSel = op; vlIn = vl; predMask = mask; condAll = cAll;
  endtask

  task automatic waitDone(inout int cnt);
    while (!done && cnt < 40) begin
      @(negedge clk);
      cnt++;
    end
  endtask

  task automatic checkSlots(input logic [3:0] vl, input logic [7:0] mask,
                            input logic [2:0] op);
    int low;
    low = -1;
    for (int i = 0; i < NV; i++) begin
      if (mask[i] && i < int'(vl)) begin
        if (low < 0) begin
          low = i;
          chk("R5 R1 R3", $sformatf("fold result slot %0d op %0d", i, op),
              destOut[i*DW +: DW], expSlot[i]);
        end else begin
          chk("R6", $sformatf("tree slot %0d", i), destOut[i*DW +: DW], expSlot[i]);
        end
      end else begin
        chk("R4", $sformatf("masked slot %0d", i), destOut[i*DW +: DW], expSlot[i]);
      end
    end
  endtask

  initial begin
    vec_t v;
    int cnt;
    logic [NV*DW-1:0] prevDest;
    logic prevFlag;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10: reset state
    chk("R10", "destOut after reset", destOut[31:0] | destOut[255:224], 32'h0);
    chk("R10", "done after reset", {31'h0, done}, 32'h0);
    chk("R10", "illegalOp after reset", {31'h0, illegalOp}, 32'h0);
    chk("R10", "condFlag after reset", {31'h0, condFlag}, 32'h0);

    // Table-driven runs
    for (int t = 0; t < NVEC; t++) begin
      v = TABLE[t];
      for (int i = 0; i < NV; i++) begin
        elemV[i] = {28'h0, v.seed[i*4 +: 4]} * 32'h11111111;
        destV[i] = 32'hDE000000 | (t << 8) | i;
      end
      model(v.op, v.vl, v.mask, v.cAll);
      drive(v.op, v.vl, v.mask, v.cAll);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cnt = 0;
      waitDone(cnt);
      chk("R8", $sformatf("latency vector %0d", t), cnt, {28'h0, v.lat});
      chk("R2", "illegalOp low on legal run", {31'h0, illegalOp}, 32'h0);
      chk("R7", $sformatf("condFlag vector %0d", t), {31'h0, condFlag}, {31'h0, expFlag});
      checkSlots(v.vl, v.mask, v.op);
      @(negedge clk);
      chk("R8", "done is a single pulse", {31'h0, done}, 32'h0);
    end

    // R2: order-dependent codes are refused
    for (int c = 5; c < 8; c++) begin
      prevDest = destOut;
      prevFlag = condFlag;
      for (int i = 0; i < NV; i++) begin
        elemV[i] = 32'h100 + i;
        destV[i] = 32'h200 + i;
      end
      drive(3'(c), 4'd8, 8'hFF, 1'b0);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cnt = 0;
      waitDone(cnt);
      chk("R2", $sformatf("refusal latency op %0d", c), cnt, 32'h0);
      chk("R2", "illegalOp raised", {31'h0, illegalOp}, 32'h1);
      chk("R2", "destOut unchanged low", destOut[127:0] == prevDest[127:0], 32'h1);
      chk("R2", "destOut unchanged high", destOut[255:128] == prevDest[255:128], 32'h1);
      chk("R2", "condFlag unchanged", {31'h0, condFlag}, {31'h0, prevFlag});
      @(negedge clk);
      chk("R2", "illegalOp single pulse", {31'h0, illegalOp}, 32'h0);
    end

    // R9: a second start during a run is ignored
    for (int i = 0; i < NV; i++) begin
      elemV[i] = 32'h10 * (i + 1);
      destV[i] = 32'h0;
    end
    model(3'd0, 4'd8, 8'hFF, 1'b1);
    drive(3'd0, 4'd8, 8'hFF, 1'b1);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < NV; i++) begin
      elemV[i] = 32'h7;
      destV[i] = 32'h5;
    end
    drive(3'd1, 4'd8, 8'h0F, 1'b0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cnt = 1;
    waitDone(cnt);
    chk("R9", "latency unaffected by busy start", cnt, 32'd4);
    chk("R9", "condFlag of first run", {31'h0, condFlag}, {31'h0, expFlag});
    checkSlots(4'd8, 8'hFF, 3'd0);
    cnt = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (done) cnt++;
    end
    chk("R9", "no second done", cnt, 32'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule